// File: doc/BRIEF.md
# Complementary PWM Dead-Band Inserter

This block sits between the duty-cycle comparator of one PWM channel and the gate drivers of a half bridge. It turns the single compare level into a high-side and a low-side drive signal that are complements of each other. Before either side turns on, it inserts a programmable idle gap. The side that is turning off drops at once. The side that is turning on waits until a down counter, loaded when the compare edge is seen, has run out. The counter advances once per clock, so the gap is measured in clock cycles.

There are two programmable gap values, `dt_rise` and `dt_fall`. Under the per-edge scheme, the compare level rising (high side turning on) uses `dt_rise`, and the level falling (low side turning on) uses `dt_fall`. Under the per-pair scheme, one of the two values, chosen by `pair_pick`, applies to both edges. This lets several instances share two programmed values while each uses its own. When independent mode is selected, the pair stops being complementary. The high output then follows the compare input, the low output follows a separate input, and no gap is inserted. Complementary operation is the state the block comes out of reset in.

Top module: `cpwm_deadband`

## Requirements
- R1: While `rst` is high, both `hi_out` and `lo_out` are 0 after the first clock edge, and the internal gap counter is 0.
- R2: With `indep_mode` = 0, `hi_out` and `lo_out` are never 1 in the same cycle.
- R3: In complementary mode, a rising compare level sampled at clock edge k drives `lo_out` to 0 from edge k. If the selected gap is N, `hi_out` becomes 1 at edge k+N.
- R4: In complementary mode, a falling compare level sampled at clock edge k drives `hi_out` to 0 from edge k. If the selected gap is N, `lo_out` becomes 1 at edge k+N.
- R5: With `scheme_sel` = 0 (per-edge scheme), a rising edge uses `dt_rise` and a falling edge uses `dt_fall`.
- R6: With `scheme_sel` = 1 (per-pair scheme), both edges use `dt_rise` when `pair_pick` = 0 and `dt_fall` when `pair_pick` = 1.
- R7: A selected gap of 0 turns the incoming side on at the same clock edge that turns the other side off.
- R8: A compare edge that arrives while a gap is still counting reloads the counter with the value for the new edge. Both outputs stay 0 until that reloaded count expires.
- R9: With `indep_mode` = 1, `hi_out` follows `cmp_in` and `lo_out` follows `indep_lo_in`, each one clock later, with no gap and no exclusion.
- R10: The first clock edge after reset, and the first edge after `indep_mode` returns to 0, count as a compare edge at the current level. The incoming side waits the gap for that level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock; the gap counter steps once per cycle |
| rst | input | 1 | Synchronous active-high reset |
| cmp_in | input | 1 | Raw duty-cycle compare level (1 = high side requested) |
| indep_mode | input | 1 | 0 = complementary with gap insertion, 1 = independent outputs |
| indep_lo_in | input | 1 | Low-side source used only in independent mode |
| scheme_sel | input | 1 | 0 = gap chosen by edge direction, 1 = one gap for the whole pair |
| pair_pick | input | 1 | Per-pair scheme: 0 picks `dt_rise`, 1 picks `dt_fall` |
| dt_rise | input | CW (6) | Gap before high-side turn-on, in clock cycles |
| dt_fall | input | CW (6) | Gap before low-side turn-on, in clock cycles |
| hi_out | output | 1 | High-side drive, registered |
| lo_out | output | 1 | Low-side drive, registered |

## Verification
A gap counter loaded with the wrong value, or decremented wrongly, shows on the ports as a turn-on that comes early or late against the arithmetic edge-plus-N expectation. The bench catches this in the same pass, because it samples every cycle from the edge until one cycle past the expected turn-on. A wrong edge or entry flag shows within one cycle, either as an output turning on with no gap or as a turning-off output that stays high. Sweeping every 6-bit gap value for both directions and both schemes exposes a stuck or swapped selection on the first affected value.

// File: rtl/cpwm_pkg.sv
package cpwm_pkg;

  // How the gap value is chosen for a compare edge
  typedef enum logic {
    SCH_BY_EDGE = 1'b0,
    SCH_BY_PAIR = 1'b1
  } dt_scheme_e;

endpackage

// File: rtl/cpwm_edge_track.sv
module cpwm_edge_track (
  input  logic clk,
  input  logic rst,
  input  logic cmp_in,
  input  logic indep_mode,
  output logic rise_o,
  output logic fall_o,
  output logic event_o
);

  logic cmp_q;
  logic fresh_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cmp_q   <= 1'b0;
      fresh_q <= 1'b1;
    end else begin
      cmp_q   <= cmp_in;
      fresh_q <= indep_mode;
    end
  end

  assign rise_o  = cmp_in & ~cmp_q;
  assign fall_o  = ~cmp_in & cmp_q;
  assign event_o = (rise_o | fall_o | fresh_q) & ~indep_mode;

  // R10
  mode_entry_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(indep_mode) |-> event_o);

endmodule

// File: rtl/cpwm_dt_pick.sv
module cpwm_dt_pick #(
  parameter int CW = 6
) (
  input  cpwm_pkg::dt_scheme_e scheme,
  input  logic                 pair_pick,
  input  logic                 level,
  input  logic [CW-1:0]        dt_rise,
  input  logic [CW-1:0]        dt_fall,
  output logic [CW-1:0]        dt_o,
  output logic                 dt_zero_o
);

  always_comb begin
    if (scheme == cpwm_pkg::SCH_BY_PAIR) dt_o = pair_pick ? dt_fall : dt_rise;
    else                                 dt_o = level ? dt_rise : dt_fall;
  end

  assign dt_zero_o = (dt_o == '0);

endmodule

// File: rtl/cpwm_dt_count.sv
module cpwm_dt_count #(
  parameter int CW = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          indep_mode,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic [CW-1:0] cnt_o,
  output logic          last_o
);

  localparam logic [CW-1:0] ONE = CW'(1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || indep_mode) cnt_q <= '0;
    else if (load)         cnt_q <= load_val;
    else if (cnt_q != '0)  cnt_q <= cnt_q - ONE;
  end

  assign cnt_o  = cnt_q;
  assign last_o = (cnt_q == ONE) || (cnt_q == '0);

  // R3
  countdown_chk: assert property (@(posedge clk) disable iff (rst)
    (!indep_mode && !load && cnt_q != '0) |=> cnt_q == $past(cnt_q) - ONE);

  // R8
  reload_chk: assert property (@(posedge clk) disable iff (rst)
    (!indep_mode && load) |=> cnt_q == $past(load_val));

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> cnt_q == '0);

endmodule

// File: rtl/cpwm_deadband.sv
module cpwm_deadband #(
  parameter int CW = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cmp_in,
  input  logic          indep_mode,
  input  logic          indep_lo_in,
  input  logic          scheme_sel,
  input  logic          pair_pick,
  input  logic [CW-1:0] dt_rise,
  input  logic [CW-1:0] dt_fall,
  output logic          hi_out,
  output logic          lo_out
);

  logic          rise;
  logic          fall;
  logic          edge_ev;
  logic [CW-1:0] dt_sel;
  logic          dt_zero;
  logic [CW-1:0] cnt;
  logic          cnt_last;
  logic          drive_ok;
  logic          hi_q;
  logic          lo_q;

  cpwm_edge_track u_edge (
    .clk        (clk),
    .rst        (rst),
    .cmp_in     (cmp_in),
    .indep_mode (indep_mode),
    .rise_o     (rise),
    .fall_o     (fall),
    .event_o    (edge_ev)
  );

  cpwm_dt_pick #(.CW(CW)) u_pick (
    .scheme    (cpwm_pkg::dt_scheme_e'(scheme_sel)),
    .pair_pick (pair_pick),
    .level     (cmp_in),
    .dt_rise   (dt_rise),
    .dt_fall   (dt_fall),
    .dt_o      (dt_sel),
    .dt_zero_o (dt_zero)
  );

  cpwm_dt_count #(.CW(CW)) u_cnt (
    .clk        (clk),
    .rst        (rst),
    .indep_mode (indep_mode),
    .load       (edge_ev),
    .load_val   (dt_sel),
    .cnt_o      (cnt),
    .last_o     (cnt_last)
  );

  // Turn-on allowed now: a fresh edge with no gap, or a count that ends here
  assign drive_ok = edge_ev ? dt_zero : cnt_last;

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_q <= 1'b0;
      lo_q <= 1'b0;
    end else if (indep_mode) begin
      hi_q <= cmp_in;
      lo_q <= indep_lo_in;
    end else begin
      hi_q <= drive_ok & cmp_in;
      lo_q <= drive_ok & ~cmp_in;
    end
  end

  assign hi_out = hi_q;
  assign lo_out = lo_q;

  // R1
  reset_idle_chk: assert property (@(posedge clk)
    rst |=> (!hi_out && !lo_out));

  // R2
  no_overlap_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(indep_mode) |-> !(hi_out && lo_out));

  // R3
  rise_lo_off_chk: assert property (@(posedge clk) disable iff (rst)
    (!indep_mode && rise) |=> !lo_out);

  // R4
  fall_hi_off_chk: assert property (@(posedge clk) disable iff (rst)
    (!indep_mode && fall) |=> !hi_out);

  // R8
  gap_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!indep_mode && !edge_ev && cnt > CW'(1)) |=> (!hi_out && !lo_out));

  // R7
  zero_gap_chk: assert property (@(posedge clk) disable iff (rst)
    (!indep_mode && edge_ev && dt_sel == '0) |=>
      (hi_out == $past(cmp_in) && lo_out == !$past(cmp_in)));

  // R9
  indep_follow_chk: assert property (@(posedge clk) disable iff (rst)
    indep_mode |=> (hi_out == $past(cmp_in) && lo_out == $past(indep_lo_in)));

endmodule

// File: tb/test_cpwm_deadband.sv
module test_cpwm_deadband;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cmp_in = 1'b0;
  logic       indep_mode = 1'b0;
  logic       indep_lo_in = 1'b0;
  logic       scheme_sel = 1'b0;
  logic       pair_pick = 1'b0;
  logic [5:0] dt_rise = 6'd0;
  logic [5:0] dt_fall = 6'd0;
  logic       hi_out;
  logic       lo_out;

  int n_cmp = 0;
  int n_bad = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cpwm_deadband #(.CW(6)) i_cpwm_deadband (
    .clk         (clk),
    .rst         (rst),
    .cmp_in      (cmp_in),
    .indep_mode  (indep_mode),
    .indep_lo_in (indep_lo_in),
    .scheme_sel  (scheme_sel),
    .pair_pick   (pair_pick),
    .dt_rise     (dt_rise),
    .dt_fall     (dt_fall),
    .hi_out      (hi_out),
    .lo_out      (lo_out)
  );

  task automatic check(input bit exp_h, input bit exp_l, input string req);
    n_cmp++;
    if (hi_out !== exp_h || lo_out !== exp_l) begin
      n_bad++;
      $display("FAIL %s: hi/lo got %b%b expected %b%b at %0t",
               req, hi_out, lo_out, exp_h, exp_l, $time);
    end
  endtask

  // One compare edge from a settled level; on side expected at offset >= n
  task automatic edge_case(input bit dir, input bit sch, input bit pick,
                           input logic [5:0] a, input logic [5:0] b);
    int n;
    string tag;
    @(negedge clk);
    indep_mode = 1'b0; scheme_sel = sch; pair_pick = pick;
    dt_rise = a; dt_fall = b; cmp_in = !dir;
    repeat (70) @(negedge clk);
    check(!dir, dir, "R2");
    n = sch ? int'(pick ? b : a) : int'(dir ? a : b);
    if (sch)         tag = "R6";
    else if (n == 0) tag = "R7";
    else             tag = dir ? "R3/R5" : "R4/R5";
    cmp_in = dir;
    for (int j = 0; j <= n + 1; j++) begin
      @(negedge clk);
      if (dir) check(j >= n, 1'b0, tag);
      else     check(1'b0, j >= n, tag);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG && !done) begin
      done = 1'b1;
      n_bad++;
      $display("FAIL watchdog: got %0d cycles expected < %0d", cycles, WATCHDOG);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    // R1: reset holds both outputs low
    dt_fall = 6'd5;
    repeat (3) @(negedge clk);
    check(1'b0, 1'b0, "R1");
    @(negedge clk);
    check(1'b0, 1'b0, "R1");
    rst = 1'b0;
    // R10: first edge after reset behaves as a falling-level edge, gap 5
    for (int j = 0; j <= 6; j++) begin
      @(negedge clk);
      check(1'b0, j >= 5, "R10");
    end

    // R9: independent mode, all input pairs including both high
    @(negedge clk);
    indep_mode = 1'b1;
    for (int r = 0; r < 2; r++) begin
      for (int v = 0; v < 4; v++) begin
        cmp_in = v[0]; indep_lo_in = v[1];
        @(negedge clk);
        check(v[0], v[1], "R9");
      end
    end

    // R10: return to complementary with compare high, gap dt_rise = 9
    cmp_in = 1'b1; indep_lo_in = 1'b0; dt_rise = 6'd9; scheme_sel = 1'b0;
    repeat (3) @(negedge clk);
    indep_mode = 1'b0;
    for (int j = 0; j <= 10; j++) begin
      @(negedge clk);
      check(j >= 9, 1'b0, "R10");
    end

    // R8: retrigger during a running gap
    @(negedge clk);
    dt_rise = 6'd10; dt_fall = 6'd7; cmp_in = 1'b0;
    repeat (20) @(negedge clk);
    cmp_in = 1'b1;
    for (int j = 0; j < 4; j++) begin
      @(negedge clk);
      check(1'b0, 1'b0, "R8");
    end
    cmp_in = 1'b0;
    for (int j = 0; j <= 8; j++) begin
      @(negedge clk);
      check(1'b0, j >= 7, "R8");
    end

    // R3 R4 R5 R7: per-edge scheme, every gap value both directions
    for (int d = 0; d < 2; d++)
      for (int a = 0; a < 64; a++)
        edge_case(d[0], 1'b0, 1'b0, 6'(a), 6'(63 - a));

    // R6: per-pair scheme, both picks, both directions
    for (int p = 0; p < 2; p++)
      for (int d = 0; d < 2; d++)
        for (int a = 0; a < 64; a++)
          edge_case(d[0], 1'b1, p[0], 6'(a), 6'((a * 5 + 3) % 64));

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule